// File: doc/BRIEF.md
# Playback Sample Request Tracker

This block follows which playback sample the converter will ask for next and tells the host when the playback data port can take a new value. The host can poll a ready flag (programmed I/O) or answer a DMA request line. The block also holds a channel pointer. In stereo the pointer picks left or right. In ADPCM it picks the first or second byte pair of a four-byte group, which carries eight samples. The block also holds the interrupt status bit, which drives the IRQ pin.

The converter pulses `consume` each time it takes the held playback value. The host's writes to the data port and to the status port arrive as single-cycle strobes. A sample-count-expired pulse raises the interrupt. A transfer-disable control can hold the DMA request off while an interrupt is pending, so that the host can service the interrupt before more data moves.

Top module: `playback_req_tracker`

## Requirements
- R1: A data-port write (`data_wr`) clears the ready flag (`pb_stat[1]`) at the next clock edge. This holds even when `consume` is high in the same cycle.
- R2: A `consume` pulse with no data-port write in the same cycle sets the ready flag at the next clock edge. With neither strobe, the ready flag holds its value.
- R3: In stereo (`fmt` = 00) and ADPCM (`fmt` = 10) formats, each `consume` inverts the channel pointer (`pb_stat[2]`) at the next edge. Code 11 is handled as stereo. Without `consume`, the pointer holds.
- R4: In mono format (`fmt` = 01), the channel pointer is 1 after every clock edge, whether or not `consume` is high.
- R5: A status-port write (`status_wr`) of any value clears the interrupt bit (`pb_stat[0]`) at the next edge, unless `cnt_done` is high in that cycle.
- R6: A `cnt_done` pulse sets the interrupt bit at the next edge. It wins over a status-port write in the same cycle.
- R7: With `xfer_dis` = 0, `pb_drq` equals the ready flag. With `xfer_dis` = 1, `pb_drq` is the ready flag and-ed with the inverse of the interrupt bit.
- R8: `pb_drq` is low in the cycle after any data-port write.
- R9: `irq` equals the interrupt bit while `irq_en` = 1, and is 0 while `irq_en` = 0.
- R10: After reset, the ready flag is 1, the channel pointer is 1 and the interrupt bit is 0. `pb_stat` is ordered {pointer, ready, interrupt}, from bit 2 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| consume | input | 1 | Converter has taken the held playback value |
| data_wr | input | 1 | Host write to the playback data port |
| status_wr | input | 1 | Host write to the status port |
| cnt_done | input | 1 | Sample-count-expired pulse |
| fmt | input | 2 | 00 stereo, 01 mono, 10 ADPCM, 11 stereo |
| xfer_dis | input | 1 | Hold DMA requests off while an interrupt is pending |
| irq_en | input | 1 | Let the interrupt bit reach the IRQ pin |
| pb_stat | output | 3 | {channel pointer, ready flag, interrupt bit} |
| pb_drq | output | 1 | Playback DMA request |
| irq | output | 1 | Interrupt pin |

## Verification
The bench aims at strobes that collide in one cycle. If `data_wr` and `consume` arrive together, a design that gives `consume` priority would leave the port marked stale and invite an overwrite. If `cnt_done` and `status_wr` arrive together, a design that lets the clear win would drop an interrupt. The bench also switches the format between mono and the two-channel formats while consumes are in flight, which catches a pointer that toggles in mono or stalls in ADPCM. It toggles `xfer_dis` and `irq_en` while the interrupt is pending, which catches a DMA request that leaks through the gate or an IRQ that ignores its enable.

// File: rtl/playback_req_tracker.sv
module playback_req_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       consume,
  input  logic       data_wr,
  input  logic       status_wr,
  input  logic       cnt_done,
  input  logic [1:0] fmt,
  input  logic       xfer_dis,
  input  logic       irq_en,
  output logic [2:0] pb_stat,
  output logic       pb_drq,
  output logic       irq
);
  localparam logic [1:0] FMT_MONO = 2'b01;

  logic stale_q, left_q, int_q;
  logic is_mono;

  assign is_mono = (fmt == FMT_MONO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q <= 1'b1;
      left_q  <= 1'b1;
      int_q   <= 1'b0;
    end else begin
      if (data_wr)      stale_q <= 1'b0;
      else if (consume) stale_q <= 1'b1;

      if (is_mono)      left_q <= 1'b1;
      else if (consume) left_q <= ~left_q;

      if (cnt_done)       int_q <= 1'b1;
      else if (status_wr) int_q <= 1'b0;
    end
  end

  assign pb_stat = {left_q, stale_q, int_q};
  assign pb_drq  = stale_q & ~(xfer_dis & int_q);
  assign irq     = int_q & irq_en;
endmodule

module playback_req_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       consume,
  input logic       data_wr,
  input logic       status_wr,
  input logic       cnt_done,
  input logic [1:0] fmt,
  input logic       xfer_dis,
  input logic       irq_en,
  input logic [2:0] pb_stat,
  input logic       pb_drq,
  input logic       irq
);
  p_wr_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !pb_stat[1]);
  p_consume_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !data_wr) |=> pb_stat[1]);
  p_ready_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !data_wr) |=> $stable(pb_stat[1]));
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && fmt != 2'b01) |=> pb_stat[2] != $past(pb_stat[2]));
  p_mono_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'b01) |=> pb_stat[2]);
  p_int_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !cnt_done) |=> !pb_stat[0]);
  p_int_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_done |=> pb_stat[0]);
  p_drq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_dis && pb_stat[0]) |-> !pb_drq);
  p_drq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !pb_drq);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind playback_req_tracker playback_req_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .consume(consume), .data_wr(data_wr),
  .status_wr(status_wr), .cnt_done(cnt_done), .fmt(fmt),
  .xfer_dis(xfer_dis), .irq_en(irq_en), .pb_stat(pb_stat),
  .pb_drq(pb_drq), .irq(irq)
);

// File: tb/playback_req_tracker_test.sv
module playback_req_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic consume = 1'b0, data_wr = 1'b0, status_wr = 1'b0, cnt_done = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic xfer_dis = 1'b0, irq_en = 1'b0;
  logic [2:0] pb_stat;
  logic pb_drq, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit m_ready, m_left, m_int;

  always #5 clk = ~clk;

  playback_req_tracker uut (
    .clk(clk), .rst_n(rst_n), .consume(consume), .data_wr(data_wr),
    .status_wr(status_wr), .cnt_done(cnt_done), .fmt(fmt),
    .xfer_dis(xfer_dis), .irq_en(irq_en), .pb_stat(pb_stat),
    .pb_drq(pb_drq), .irq(irq)
  );

  task automatic check(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1 R2 ready", pb_stat[1], m_ready);
    check("R3 R4 pointer", pb_stat[2], m_left);
    check("R5 R6 interrupt", pb_stat[0], m_int);
    check("R7 R8 drq", pb_drq, m_ready && !(xfer_dis && m_int));
    check("R9 irq", irq, m_int && irq_en);
  endtask

  task automatic apply(input bit c, input bit dw, input bit sw, input bit cd,
                       input bit [1:0] f, input bit td, input bit ie);
    consume = c; data_wr = dw; status_wr = sw; cnt_done = cd;
    fmt = f; xfer_dis = td; irq_en = ie;
    if (dw) m_ready = 1'b0; else if (c) m_ready = 1'b1;
    if (f == 2'b01) m_left = 1'b1; else if (c) m_left = !m_left;
    if (cd) m_int = 1'b1; else if (sw) m_int = 1'b0;
  endtask

  task automatic step(input bit c, input bit dw, input bit sw, input bit cd,
                      input bit [1:0] f, input bit td, input bit ie);
    apply(c, dw, sw, cd, f, td, ie);
    @(negedge clk);
    cyc++;
    compare_all();
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog all-requirements actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ready = 1'b1; m_left = 1'b1; m_int = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset ready", pb_stat[1], 1'b1);
    check("R10 reset pointer", pb_stat[2], 1'b1);
    check("R10 reset interrupt", pb_stat[0], 1'b0);
    check("R10 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R1/R8 write then R2/R3 consume, stereo
    step(0,1,0,0,2'b00,0,1);
    step(1,0,0,0,2'b00,0,1);
    // R1 both strobes in one cycle: write wins
    step(1,1,0,0,2'b00,0,1);
    // R6 set wins over R5 clear
    step(0,0,1,1,2'b00,1,1);
    step(1,0,0,0,2'b00,1,1);   // R7 gated with xfer_dis and int
    step(0,0,0,0,2'b00,1,0);   // R9 masked
    step(0,0,1,0,2'b00,1,1);   // R5 clear
    // R4 mono: pointer pinned while consuming
    step(1,0,0,0,2'b01,0,1);
    step(1,1,0,0,2'b01,0,1);
    // R3 ADPCM halves
    step(1,0,0,0,2'b10,0,1);
    step(1,0,0,0,2'b10,0,1);
    step(1,0,0,0,2'b11,0,1);
    for (int i = 0; i < 4000; i++) begin
      bit [1:0] f;
      f = 2'($urandom_range(0, 3));
      step(($urandom_range(0,2) == 0), ($urandom_range(0,3) == 0),
           ($urandom_range(0,4) == 0), ($urandom_range(0,6) == 0),
           f, ($urandom_range(0,1) == 1), ($urandom_range(0,3) != 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule